// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address through a small set of block-translation entries. It holds two banks of four entries each: one bank serves instruction fetches and the other serves every other access. Each entry is a pair of 32-bit words. The tag word gives the effective block index, a block-length mask and two validity bits, one for supervisor and one for user. The map word gives the physical block base and the access permission.

A request presents an address, its access kind and the processor privilege and translation-enable bits. One cycle later the block returns one of four outcomes. The address can be passed through untranslated. It can be translated by the lowest-numbered usable entry. It can be refused as a miss, and a miss loads the fault-address register. A write port loads any word of either bank. Page-table translation after a miss is left to a later stage.

The control is a four-state result machine: `ST_IDLE` (no result), `ST_BYPASS` (translation off), `ST_HIT` (an entry translated) and `ST_MISS` (no usable entry). Every clock edge takes the machine to a state chosen from the request in that cycle. A cycle without a request goes to `ST_IDLE`. A request with translation off goes to `ST_BYPASS`. A request that an entry matches goes to `ST_HIT`. Any other request goes to `ST_MISS`. Any state can move to any of the four.

Top module: `bat_xlate`

## Requirements
- R1: A request with `req_fetch`=1 looks only at the instruction bank (`cfg_dside`=0). A request with `req_fetch`=0 looks only at the data bank (`cfg_dside`=1).
- R2: An entry's address matches when address bits 31:28 equal tag bits 31:28. In addition, address bits 27:17 with the mask bits cleared must equal tag bits 27:17. The mask comes from tag bits 12:2, with tag bit 2+k masking address bit 17+k.
- R3: A matching entry is usable only when tag bit 1 is set while `msr_pr`=0, or when tag bit 0 is set while `msr_pr`=1.
- R4: On a hit, the physical address takes bits 31:28 from map bits 31:28. Bits 27:17 are (address 27:17 AND mask) OR map 27:17, and bits 16:0 are address bits 16:0.
- R5: On a hit, map bit 1 set grants read and write. Map bit 0 alone grants read only. With neither bit set the result is still a hit, but with no permission.
- R6: When several entries are usable, the one with the lowest index supplies the result.
- R7: A translated request that finds no usable entry returns `rsp_hit`=0 and loads `fault_addr` with the request address. On any other outcome `fault_addr` keeps its value.
- R8: When `msr_dr`=0, or when `req_fetch`=1 and `msr_ir`=0, the request returns a hit with the address unchanged and both read and write granted.
- R9: The result appears with `rsp_valid`=1 in the cycle after `req_valid`=1. In the cycle after `req_valid`=0, `rsp_valid`, `rsp_hit`, `rsp_rd` and `rsp_wr` are 0.
- R10: When `cfg_we`=1, `cfg_wdata` is written to entry `cfg_idx` of the bank picked by `cfg_dside`. The word written is the map word when `cfg_lower`=1 and the tag word otherwise. The new value applies only to requests in later cycles.
- R11: Reset clears all entry words and `fault_addr` and leaves `rsp_valid` at 0, so any translated request misses until entries are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_addr | input | 32 | Effective address |
| msr_pr | input | 1 | Privilege: 0 supervisor, 1 user |
| msr_ir | input | 1 | Instruction translation enable |
| msr_dr | input | 1 | Data translation enable |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_dside | input | 1 | Bank select: 0 instruction, 1 data |
| cfg_lower | input | 1 | Word select: 0 tag, 1 map |
| cfg_idx | input | 2 | Entry index |
| cfg_wdata | input | 32 | Word to write |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Address translated or passed through |
| rsp_paddr | output | 32 | Physical address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| fault_addr | output | 32 | Address of the last miss |

## Verification
The bench loads entries that overlap on purpose and then aims at the masked compare. A design that masks the wrong field, or forgets to fold the masked address bits into the physical address, returns the wrong block for a wide entry and for a one-bit-wide mask. It also probes the split validity bits and priority: a design that ignores privilege, or lets a higher entry win, returns the user mapping for a supervisor access or the wrong permission. The bypass vectors check that data translation off also bypasses fetches, and that a miss in the instruction bank is not rescued by a data entry. They also check that the fault register moves only on a miss. The bench writes an entry in the same cycle as a lookup; a design that forwards the new word returns the new mapping one request too early.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int unsigned VA_W     = 32;
    localparam int unsigned HI_MSB   = 31;
    localparam int unsigned HI_LSB   = 28;
    localparam int unsigned MID_MSB  = 27;
    localparam int unsigned MID_LSB  = 17;
    localparam int unsigned MID_W    = MID_MSB - MID_LSB + 1;
    localparam int unsigned LEN_LSB  = 2;
    localparam int unsigned LEN_MSB  = LEN_LSB + MID_W - 1;
    localparam int unsigned SUP_BIT  = 1;
    localparam int unsigned USR_BIT  = 0;
    localparam int unsigned RW_BIT   = 1;
    localparam int unsigned RO_BIT   = 0;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BYPASS = 2'd1,
        ST_HIT    = 2'd2,
        ST_MISS   = 2'd3
    } xl_state_e;

    typedef struct packed {
        logic [VA_W-1:0] paddr;
        logic            rd;
        logic            wr;
    } xl_res_t;

endpackage

// File: rtl/bat_regbank.sv
module bat_regbank
    import bat_pkg::*;
#(
    parameter int N_ENTRY = 4,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_dside,
    input  logic                          wr_lower,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [VA_W-1:0]               wr_data,
    input  logic                          rd_dside,
    output logic [N_ENTRY-1:0][VA_W-1:0]  tag_o,
    output logic [N_ENTRY-1:0][VA_W-1:0]  map_o
);

    logic [1:0][N_ENTRY-1:0][VA_W-1:0] tag_q;
    logic [1:0][N_ENTRY-1:0][VA_W-1:0] map_q;

    for (genvar s = 0; s < 2; s++) begin : g_bank
        for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
            logic sel;
            assign sel = wr_en && (wr_dside == 1'(s)) && (wr_idx == IDX_W'(e));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tag_q[s][e] <= '0;
                    map_q[s][e] <= '0;
                end else if (sel) begin
                    if (wr_lower) map_q[s][e] <= wr_data;
                    else          tag_q[s][e] <= wr_data;
                end
            end
        end
    end

    assign tag_o = rd_dside ? tag_q[1] : tag_q[0];
    assign map_o = rd_dside ? map_q[1] : map_q[0];

endmodule

// File: rtl/bat_entry_cmp.sv
module bat_entry_cmp
    import bat_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] tag,
    input  logic [VA_W-1:0] map,
    input  logic            pr,
    output logic            usable,
    output xl_res_t         res
);

    logic [MID_W-1:0] len_mask;
    logic             hi_ok;
    logic             mid_ok;
    logic             priv_ok;
    logic             unused_bits;

    assign len_mask = tag[LEN_MSB:LEN_LSB];
    assign hi_ok    = (va[HI_MSB:HI_LSB] == tag[HI_MSB:HI_LSB]);
    assign mid_ok   = ((va[MID_MSB:MID_LSB] & ~len_mask) == tag[MID_MSB:MID_LSB]);
    assign priv_ok  = pr ? tag[USR_BIT] : tag[SUP_BIT];
    assign usable   = hi_ok && mid_ok && priv_ok;

    assign res.paddr = {map[HI_MSB:HI_LSB],
                        (va[MID_MSB:MID_LSB] & len_mask) | map[MID_MSB:MID_LSB],
                        va[MID_LSB-1:0]};
    assign res.wr    = map[RW_BIT];
    assign res.rd    = map[RW_BIT] | map[RO_BIT];

    assign unused_bits = ^{tag[MID_LSB-1:LEN_MSB+1], map[MID_LSB-1:RW_BIT+1]};

endmodule

// File: rtl/bat_prio_pick.sv
module bat_prio_pick
    import bat_pkg::*;
#(
    parameter int N_ENTRY = 4
) (
    input  logic    [N_ENTRY-1:0] usable,
    input  xl_res_t [N_ENTRY-1:0] res,
    output logic                  hit,
    output xl_res_t               sel
);

    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < N_ENTRY; i++) begin
            if (usable[i] && !found) begin
                sel   = res[i];
                found = 1'b1;
            end
        end
        hit = found;
    end

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int N_ENTRY = 4,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_fetch,
    input  logic [31:0]      req_addr,
    input  logic             msr_pr,
    input  logic             msr_ir,
    input  logic             msr_dr,
    input  logic             cfg_we,
    input  logic             cfg_dside,
    input  logic             cfg_lower,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [31:0]      cfg_wdata,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [31:0]      rsp_paddr,
    output logic             rsp_rd,
    output logic             rsp_wr,
    output logic [31:0]      fault_addr
);

    logic [N_ENTRY-1:0][VA_W-1:0] tag_w;
    logic [N_ENTRY-1:0][VA_W-1:0] map_w;
    logic    [N_ENTRY-1:0]        usable_w;
    xl_res_t [N_ENTRY-1:0]        res_w;
    xl_res_t                      pick_w;
    logic                         any_hit;
    logic                         xl_off;

    xl_state_e       state_q, state_d;
    logic [VA_W-1:0] paddr_q, fault_q;
    logic            rd_q, wr_q;

    bat_regbank #(.N_ENTRY(N_ENTRY)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_dside (cfg_dside),
        .wr_lower (cfg_lower),
        .wr_idx   (cfg_idx),
        .wr_data  (cfg_wdata),
        .rd_dside (!req_fetch),
        .tag_o    (tag_w),
        .map_o    (map_w)
    );

    for (genvar e = 0; e < N_ENTRY; e++) begin : g_cmp
        bat_entry_cmp u_cmp (
            .va     (req_addr),
            .tag    (tag_w[e]),
            .map    (map_w[e]),
            .pr     (msr_pr),
            .usable (usable_w[e]),
            .res    (res_w[e])
        );
    end

    bat_prio_pick #(.N_ENTRY(N_ENTRY)) u_pick (
        .usable (usable_w),
        .res    (res_w),
        .hit    (any_hit),
        .sel    (pick_w)
    );

    assign xl_off = !msr_dr || (req_fetch && !msr_ir);

    // next-state selection
    always_comb begin
        if (!req_valid)   state_d = ST_IDLE;
        else if (xl_off)  state_d = ST_BYPASS;
        else if (any_hit) state_d = ST_HIT;
        else              state_d = ST_MISS;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result and fault registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paddr_q <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            fault_q <= '0;
        end else begin
            unique case (state_d)
                ST_BYPASS: begin
                    paddr_q <= req_addr;
                    rd_q    <= 1'b1;
                    wr_q    <= 1'b1;
                end
                ST_HIT: begin
                    paddr_q <= pick_w.paddr;
                    rd_q    <= pick_w.rd;
                    wr_q    <= pick_w.wr;
                end
                ST_MISS: begin
                    rd_q    <= 1'b0;
                    wr_q    <= 1'b0;
                    fault_q <= req_addr;
                end
                default: begin
                    rd_q    <= 1'b0;
                    wr_q    <= 1'b0;
                end
            endcase
        end
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            ST_BYPASS, ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b0;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_hit   = 1'b0;
            end
        endcase
        rsp_rd = rsp_hit && rd_q;
        rsp_wr = rsp_hit && wr_q;
    end

    assign rsp_paddr  = paddr_q;
    assign fault_addr = fault_q;

    p_resp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_when_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_rd && !rsp_wr));

    p_miss_captures_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xl_off && !any_hit) |=> (!rsp_hit && fault_addr == $past(req_addr)));

    p_fault_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $stable(fault_addr));

    p_bypass_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xl_off) |=>
            (rsp_hit && rsp_paddr == $past(req_addr) && rsp_rd && rsp_wr));

    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_hit) |=> (rsp_paddr[MID_LSB-1:0] == $past(req_addr[MID_LSB-1:0])));

    p_write_needs_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr |-> rsp_rd);

endmodule

// File: tb/test_bat_xlate.sv
`timescale 1ns/1ps
module test_bat_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_fetch = 1'b0;
    logic [31:0] req_addr = '0;
    logic        msr_pr = 1'b0, msr_ir = 1'b1, msr_dr = 1'b1;
    logic        cfg_we = 1'b0, cfg_dside = 1'b0, cfg_lower = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr;
    logic [31:0] rsp_paddr, fault_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_fault = '0;

    always #5 clk = ~clk;

    bat_xlate i_bat_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_fetch(req_fetch), .req_addr(req_addr),
        .msr_pr(msr_pr), .msr_ir(msr_ir), .msr_dr(msr_dr),
        .cfg_we(cfg_we), .cfg_dside(cfg_dside), .cfg_lower(cfg_lower),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .fault_addr(fault_addr)
    );

    typedef struct packed {
        logic        fetch;
        logic        pr;
        logic        ir;
        logic        dr;
        logic [31:0] addr;
        logic        ehit;
        logic [31:0] epa;
        logic        erd;
        logic        ewr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,1'b1,32'h8001_2345, 1'b1,32'h1001_2345,1'b1,1'b1}, // R3 supervisor entry, R6
        '{1'b0,1'b1,1'b1,1'b1,32'h8001_2345, 1'b1,32'h2001_2345,1'b1,1'b0}, // R3 user entry
        '{1'b0,1'b0,1'b1,1'b1,32'h8002_0000, 1'b0,32'h0,        1'b0,1'b0}, // R2 unmasked bit differs
        '{1'b0,1'b0,1'b1,1'b1,32'hA123_4567, 1'b1,32'h3123_4567,1'b0,1'b0}, // R2 wide mask, R5 no perm
        '{1'b0,1'b1,1'b1,1'b1,32'hC006_1234, 1'b1,32'h500A_1234,1'b1,1'b1}, // R4 masked bit folded
        '{1'b0,1'b1,1'b1,1'b1,32'hC004_0010, 1'b1,32'h5008_0010,1'b1,1'b1}, // R4
        '{1'b0,1'b0,1'b1,1'b1,32'hC008_0000, 1'b0,32'h0,        1'b0,1'b0}, // R2 miss
        '{1'b1,1'b0,1'b1,1'b1,32'h8001_2345, 1'b1,32'h7001_2345,1'b1,1'b0}, // R1 fetch bank, R6 lowest
        '{1'b1,1'b1,1'b1,1'b1,32'h8001_2345, 1'b1,32'h7001_2345,1'b1,1'b0}, // R6
        '{1'b1,1'b0,1'b0,1'b1,32'h8001_2345, 1'b1,32'h8001_2345,1'b1,1'b1}, // R8 fetch untranslated
        '{1'b0,1'b0,1'b0,1'b1,32'h8001_2345, 1'b1,32'h1001_2345,1'b1,1'b1}, // R8 ir ignored for data
        '{1'b0,1'b0,1'b1,1'b0,32'hDEAD_BEEF, 1'b1,32'hDEAD_BEEF,1'b1,1'b1}, // R8 data untranslated
        '{1'b1,1'b0,1'b1,1'b0,32'h9000_0000, 1'b1,32'h9000_0000,1'b1,1'b1}, // R8 dr off bypasses fetch
        '{1'b1,1'b0,1'b1,1'b1,32'hA000_0000, 1'b0,32'h0,        1'b0,1'b0}  // R1 data entry not used
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic ds, input logic lo, input logic [1:0] idx, input logic [31:0] d);
        cfg_we = 1'b1; cfg_dside = ds; cfg_lower = lo; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic f, input logic p, input logic i, input logic d, input logic [31:0] a);
        req_valid = 1'b1; req_fetch = f; msr_pr = p; msr_ir = i; msr_dr = d; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic h, input logic [31:0] pa,
                              input logic r, input logic w);
        chk({tag, " valid R9"}, 32'(rsp_valid), 32'd1);
        chk({tag, " hit R2"}, 32'(rsp_hit), 32'(h));
        if (h) chk({tag, " paddr R4"}, rsp_paddr, pa);
        chk({tag, " perm R5"}, {30'd0, rsp_rd, rsp_wr}, {30'd0, r, w});
        chk({tag, " fault R7"}, fault_addr, exp_fault);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R11 fault", fault_addr, 32'd0);
        // R11 empty banks miss
        lookup(1'b0, 1'b0, 1'b1, 1'b1, 32'h8001_2345);
        exp_fault = 32'h8001_2345;
        expect_res("R11 empty", 1'b0, 32'h0, 1'b0, 1'b0);

        // R10 entry loading
        cfg(1'b1, 1'b0, 2'd0, 32'h8000_0002); cfg(1'b1, 1'b1, 2'd0, 32'h1000_0002);
        cfg(1'b1, 1'b0, 2'd1, 32'h8000_0001); cfg(1'b1, 1'b1, 2'd1, 32'h2000_0001);
        cfg(1'b1, 1'b0, 2'd2, 32'hA000_1FFF); cfg(1'b1, 1'b1, 2'd2, 32'h3000_0000);
        cfg(1'b1, 1'b0, 2'd3, 32'hC004_0007); cfg(1'b1, 1'b1, 2'd3, 32'h5008_0003);
        cfg(1'b0, 1'b0, 2'd0, 32'h8000_0003); cfg(1'b0, 1'b1, 2'd0, 32'h7000_0001);
        cfg(1'b0, 1'b0, 2'd1, 32'h8000_0003); cfg(1'b0, 1'b1, 2'd1, 32'h6000_0002);

        for (int v = 0; v < NV; v++) begin
            lookup(VECS[v].fetch, VECS[v].pr, VECS[v].ir, VECS[v].dr, VECS[v].addr);
            if (!VECS[v].ehit) exp_fault = VECS[v].addr;
            expect_res($sformatf("vec%0d", v), VECS[v].ehit, VECS[v].epa, VECS[v].erd, VECS[v].ewr);
        end

        // R9 idle cycle
        @(negedge clk);
        chk("R9 idle valid", 32'(rsp_valid), 32'd0);
        chk("R9 idle perm", {30'd0, rsp_rd, rsp_wr}, 32'd0);

        // R10 write in the same cycle as a lookup: old mapping used
        cfg_we = 1'b1; cfg_dside = 1'b1; cfg_lower = 1'b1; cfg_idx = 2'd0; cfg_wdata = 32'h4000_0001;
        lookup(1'b0, 1'b0, 1'b1, 1'b1, 32'h8001_2345);
        cfg_we = 1'b0;
        expect_res("R10 same cycle", 1'b1, 32'h1001_2345, 1'b1, 1'b1);
        lookup(1'b0, 1'b0, 1'b1, 1'b1, 32'h8001_2345);
        expect_res("R10 next cycle", 1'b1, 32'h4001_2345, 1'b1, 1'b0);

        // R10 R1 instruction bank write leaves data bank alone
        cfg(1'b0, 1'b0, 2'd2, 32'hE000_0003);
        lookup(1'b0, 1'b0, 1'b1, 1'b1, 32'hE000_0040);
        exp_fault = 32'hE000_0040;
        expect_res("R1 data side", 1'b0, 32'h0, 1'b0, 1'b0);
        lookup(1'b1, 1'b0, 1'b1, 1'b1, 32'hE000_0040);
        expect_res("R1 fetch side", 1'b1, 32'h0000_0040, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule